// File: doc/BRIEF.md
# Tagged Branch Target Buffer with Return Stack

This block sits in the fetch stage and guesses the next fetch address. Each cycle the fetch unit may present a PC. One clock later the block reports three things: whether a stored entry belongs to that PC, the target it recorded, and whether that branch is expected to be taken. Entries live in a direct-mapped table. The table is indexed by low PC bits and guarded by a full tag of the remaining upper bits, so a stored target is never handed to a different branch that shares the same slot.

The execute stage reports resolved branches on a separate resolve port. A taken branch allocates or refreshes its slot. A not-taken branch only modifies an entry that is already present. Return instructions are not predicted from the table. A small return-address stack is pushed by calls and popped by returns, and the popped address is presented one clock after the pop.

Lookups, resolves and stack operations are single-cycle strobes. The block accepts one of each every clock and never stalls, so no ready signal exists and nothing is held back. A strobe that is low means no request that cycle.

Top module: `btb_predictor`

## Requirements
- R1: After reset no table entry is valid and the stack is empty; `pred_hit`, `pred_taken`, `pred_target`, `ras_valid` and `ras_addr` are all zero.
- R2: The table index is PC bits [5:2] and the tag is PC bits [31:6]. When `lk_en` is high, the next cycle shows `pred_hit`=1 with the stored target and taken bit only if the indexed entry is valid and its tag equals the full tag of `lk_pc`. On a miss `pred_target` and `pred_taken` are zero.
- R3: A PC that shares an index with a stored entry but has a different tag gets `pred_hit`=0.
- R4: A taken resolve that misses overwrites the indexed slot with its tag, its target and taken=1. The previous occupant of that slot misses afterwards.
- R5: A not-taken resolve that hits an entry clears its taken bit and stores the resolved target. The entry keeps hitting.
- R6: A not-taken resolve that misses changes no entry.
- R7: A taken resolve that hits an entry sets its taken bit and replaces its target.
- R8: A lookup and a resolve to the same index in the same cycle return the contents from before the resolve.
- R9: When `lk_en` is low, `pred_hit` is zero in the following cycle.
- R10: The stack holds 8 addresses in last-in-first-out order. One cycle after `ras_pop` on a non-empty stack, `ras_valid`=1 and `ras_addr` is the most recently pushed address still held. Without a pop, `ras_valid` is 0 the next cycle.
- R11: A push on a full stack overwrites the oldest address. After 9 pushes, 8 pops return the last 8 pushed addresses newest first, and a 9th pop is invalid.
- R12: A pop on an empty stack gives `ras_valid`=0 and `ras_addr`=0 and leaves the stack empty.
- R13: A push and a pop in the same cycle return the current top, and the pushed address replaces it. On an empty stack the pop is invalid and the push leaves one entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_en | input | 1 | Lookup request this cycle |
| lk_pc | input | 32 | Fetch PC to look up |
| rs_en | input | 1 | Resolved branch reported this cycle |
| rs_pc | input | 32 | PC of the resolved branch |
| rs_taken | input | 1 | Resolved direction, 1 = taken |
| rs_target | input | 32 | Actual target of the resolved branch |
| ras_push | input | 1 | Call seen: push return address |
| ras_push_addr | input | 32 | Return address to push |
| ras_pop | input | 1 | Return seen: pop a predicted address |
| pred_hit | output | 1 | Previous-cycle lookup hit a valid tagged entry |
| pred_taken | output | 1 | Stored direction of the hit entry |
| pred_target | output | 32 | Stored target of the hit entry |
| ras_valid | output | 1 | Previous-cycle pop returned an address |
| ras_addr | output | 32 | Popped return address |

## Verification
A corrupted valid bit, tag or target shows up at the first lookup of that slot, one cycle later, as a wrong hit flag or a wrong target. The bench therefore reads back every slot right after each kind of resolve, and again after aliasing writes. Errors in the stack pointer or occupancy stay hidden until later pops. A wrong pointer returns addresses out of order, and a wrong count shows up at the boundary, either as a stale valid pop or as an early invalid one. For that reason the stack is drained fully after wrap, after a swap and after an empty pop.

// File: rtl/btb_pkg.sv
package btb_pkg;
  typedef enum logic [1:0] {
    RAS_IDLE = 2'd0,
    RAS_PUSH = 2'd1,
    RAS_POP  = 2'd2,
    RAS_SWAP = 2'd3
  } ras_op_e;

  function automatic ras_op_e ras_decode(input logic push, input logic pop);
    case ({push, pop})
      2'b10:   return RAS_PUSH;
      2'b01:   return RAS_POP;
      2'b11:   return RAS_SWAP;
      default: return RAS_IDLE;
    endcase
  endfunction
endpackage

// File: rtl/btb_table.sv
module btb_table #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lk_en,
  input  logic [PC_W-1:0] lk_pc,
  input  logic            rs_en,
  input  logic [PC_W-1:0] rs_pc,
  input  logic            rs_taken,
  input  logic [PC_W-1:0] rs_target,
  output logic            pred_hit,
  output logic            pred_taken,
  output logic [PC_W-1:0] pred_target
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int LO      = 2;
  localparam int TAG_LO  = IDX_W + LO;
  localparam int TAG_W   = PC_W - TAG_LO;

  logic [ENTRIES-1:0] vld_q;
  logic [ENTRIES-1:0] tkn_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [PC_W-1:0]    tgt_q [ENTRIES];

  logic [IDX_W-1:0] lk_idx, rs_idx;
  logic [TAG_W-1:0] lk_tag, rs_tag;
  logic             lk_match, rs_match, wr_go;
  logic             unused_lo;

  assign lk_idx    = lk_pc[TAG_LO-1:LO];
  assign rs_idx    = rs_pc[TAG_LO-1:LO];
  assign lk_tag    = lk_pc[PC_W-1:TAG_LO];
  assign rs_tag    = rs_pc[PC_W-1:TAG_LO];
  assign unused_lo = ^{lk_pc[LO-1:0], rs_pc[LO-1:0]};

  assign lk_match = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
  assign rs_match = vld_q[rs_idx] && (tag_q[rs_idx] == rs_tag);
  // taken outcomes allocate; not-taken outcomes only touch an existing entry
  assign wr_go    = rs_en && (rs_taken || rs_match);

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    logic sel;
    assign sel = wr_go && (rs_idx == IDX_W'(e));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q[e] <= 1'b0;
        tkn_q[e] <= 1'b0;
      end else if (sel) begin
        vld_q[e] <= 1'b1;
        tkn_q[e] <= rs_taken;
      end
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        tag_q[e] <= rs_tag;
        tgt_q[e] <= rs_target;
      end
    end
  end

  // registered read: a same-cycle write is not visible (read-before-write)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pred_hit    <= 1'b0;
      pred_taken  <= 1'b0;
      pred_target <= '0;
    end else begin
      pred_hit    <= lk_en && lk_match;
      pred_taken  <= lk_en && lk_match && tkn_q[lk_idx];
      pred_target <= (lk_en && lk_match) ? tgt_q[lk_idx] : '0;
    end
  end
endmodule

// File: rtl/btb_ras.sv
module btb_ras
  import btb_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int DEPTH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [PC_W-1:0] push_addr,
  input  logic            pop,
  output logic            pop_valid,
  output logic [PC_W-1:0] pop_addr
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_MAX = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

  logic [PC_W-1:0]  stk_q [DEPTH];
  logic [PTR_W-1:0] wp_q, wp_inc, wp_dec;
  logic [CNT_W-1:0] cnt_q;
  logic             empty, full;
  ras_op_e          op;

  assign op     = ras_decode(push, pop);
  assign empty  = (cnt_q == '0);
  assign full   = (cnt_q == CNT_MAX);
  assign wp_inc = (wp_q == PTR_MAX) ? '0 : wp_q + 1'b1;
  assign wp_dec = (wp_q == '0) ? PTR_MAX : wp_q - 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q      <= '0;
      cnt_q     <= '0;
      pop_valid <= 1'b0;
      pop_addr  <= '0;
    end else begin
      pop_valid <= 1'b0;
      pop_addr  <= '0;
      unique case (op)
        RAS_PUSH: begin
          wp_q <= wp_inc;
          if (!full) cnt_q <= cnt_q + 1'b1;
        end
        RAS_POP: begin
          if (!empty) begin
            pop_valid <= 1'b1;
            pop_addr  <= stk_q[wp_dec];
            wp_q      <= wp_dec;
            cnt_q     <= cnt_q - 1'b1;
          end
        end
        RAS_SWAP: begin
          if (!empty) begin
            pop_valid <= 1'b1;
            pop_addr  <= stk_q[wp_dec];
          end else begin
            wp_q  <= wp_inc;
            cnt_q <= CNT_W'(1);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (op == RAS_PUSH || (op == RAS_SWAP && empty))
      stk_q[wp_q] <= push_addr;
    else if (op == RAS_SWAP)
      stk_q[wp_dec] <= push_addr;
  end
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor #(
  parameter int PC_W      = 32,
  parameter int IDX_W     = 4,
  parameter int RAS_DEPTH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lk_en,
  input  logic [PC_W-1:0] lk_pc,
  input  logic            rs_en,
  input  logic [PC_W-1:0] rs_pc,
  input  logic            rs_taken,
  input  logic [PC_W-1:0] rs_target,
  input  logic            ras_push,
  input  logic [PC_W-1:0] ras_push_addr,
  input  logic            ras_pop,
  output logic            pred_hit,
  output logic            pred_taken,
  output logic [PC_W-1:0] pred_target,
  output logic            ras_valid,
  output logic [PC_W-1:0] ras_addr
);
  btb_table #(.PC_W(PC_W), .IDX_W(IDX_W)) i_table (
    .clk         (clk),
    .rst_n       (rst_n),
    .lk_en       (lk_en),
    .lk_pc       (lk_pc),
    .rs_en       (rs_en),
    .rs_pc       (rs_pc),
    .rs_taken    (rs_taken),
    .rs_target   (rs_target),
    .pred_hit    (pred_hit),
    .pred_taken  (pred_taken),
    .pred_target (pred_target)
  );

  btb_ras #(.PC_W(PC_W), .DEPTH(RAS_DEPTH)) i_ras (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (ras_push),
    .push_addr (ras_push_addr),
    .pop       (ras_pop),
    .pop_valid (ras_valid),
    .pop_addr  (ras_addr)
  );
endmodule

// File: rtl/btb_predictor_chk.sv
module btb_predictor_chk #(
  parameter int PC_W      = 32,
  parameter int IDX_W     = 4,
  parameter int RAS_DEPTH = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            lk_en,
  input logic [PC_W-1:0] lk_pc,
  input logic            rs_en,
  input logic [PC_W-1:0] rs_pc,
  input logic            rs_taken,
  input logic [PC_W-1:0] rs_target,
  input logic            ras_push,
  input logic [PC_W-1:0] ras_push_addr,
  input logic            ras_pop,
  input logic            pred_hit,
  input logic            pred_taken,
  input logic [PC_W-1:0] pred_target,
  input logic            ras_valid,
  input logic [PC_W-1:0] ras_addr
);
  localparam int OCC_W = $clog2(RAS_DEPTH + 1);
  logic [OCC_W-1:0] occ;
  logic             unused_chk;
  assign unused_chk = ^{ras_push_addr, ras_addr, pred_taken};

  // independent occupancy model of the return stack
  always_ff @(posedge clk) begin
    if (!rst_n) occ <= '0;
    else if (ras_push && !ras_pop) begin
      if (occ != OCC_W'(RAS_DEPTH)) occ <= occ + 1'b1;
    end else if (ras_pop && !ras_push) begin
      if (occ != '0) occ <= occ - 1'b1;
    end else if (ras_pop && ras_push && occ == '0) occ <= OCC_W'(1);
  end

  AST_NO_LOOKUP_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_en |=> !pred_hit); // R9

  AST_ALLOC_THEN_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_en && rs_taken) ##1 (lk_en && lk_pc == $past(rs_pc))
      |=> (pred_hit && pred_target == $past(rs_target, 2))); // R4

  AST_MISS_TARGET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !pred_hit |-> (pred_target == '0)); // R2

  AST_NO_POP_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_pop |=> !ras_valid); // R10

  AST_POP_NONEMPTY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_pop && occ != '0) |=> ras_valid); // R10

  AST_POP_EMPTY_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_pop && occ == '0) |=> !ras_valid); // R12
endmodule

bind btb_predictor btb_predictor_chk #(
  .PC_W(PC_W), .IDX_W(IDX_W), .RAS_DEPTH(RAS_DEPTH)
) i_chk (.*);

// File: tb/test_btb_predictor.sv
`timescale 1ns/1ps
module test_btb_predictor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_en, rs_en, rs_taken, ras_push, ras_pop;
  logic [31:0] lk_pc, rs_pc, rs_target, ras_push_addr;
  logic        pred_hit, pred_taken, ras_valid;
  logic [31:0] pred_target, ras_addr;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  typedef struct {
    string       req;
    bit          hit;
    bit          tkn;
    logic [31:0] tgt;
    bit          rv;
    logic [31:0] ra;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  btb_predictor i_btb_predictor (.*);

  localparam logic [31:0] PA = 32'h0000_1004; // index 1
  localparam logic [31:0] PB = 32'h0000_2004; // index 1, other tag
  localparam logic [31:0] PC = 32'h0000_3008; // index 2

  task automatic idle();
    lk_en = 0; lk_pc = '0; rs_en = 0; rs_pc = '0; rs_taken = 0;
    rs_target = '0; ras_push = 0; ras_push_addr = '0; ras_pop = 0;
  endtask

  task automatic check(string req, bit h, bit t, logic [31:0] tg, bit rv, logic [31:0] ra,
                       bit ah, bit at, logic [31:0] atg, bit arv, logic [31:0] ara);
    compared++;
    if (ah !== h || at !== t || atg !== tg || arv !== rv || ara !== ra) begin
      mismatched++;
      $display("FAIL %s: got hit=%0b tkn=%0b tgt=%h rv=%0b ra=%h exp hit=%0b tkn=%0b tgt=%h rv=%0b ra=%h",
               req, ah, at, atg, arv, ara, h, t, tg, rv, ra);
    end
  endtask

  // driver: expectation for the inputs set now, seen after the next edge
  task automatic cyc(string req, bit h, bit t, logic [31:0] tg, bit rv, logic [31:0] ra);
    exp_t e;
    e.req = req; e.hit = h; e.tkn = t; e.tgt = tg; e.rv = rv; e.ra = ra;
    sb.push_back(e);
    @(negedge clk);
    idle();
  endtask

  task automatic look(string req, logic [31:0] pc, bit h, bit t, logic [31:0] tg);
    lk_en = 1; lk_pc = pc;
    cyc(req, h, t, tg, 0, '0);
  endtask

  task automatic resolve(string req, logic [31:0] pc, bit tk, logic [31:0] tg);
    rs_en = 1; rs_pc = pc; rs_taken = tk; rs_target = tg;
    cyc(req, 0, 0, '0, 0, '0);
  endtask

  task automatic push(string req, logic [31:0] a);
    ras_push = 1; ras_push_addr = a;
    cyc(req, 0, 0, '0, 0, '0);
  endtask

  task automatic pop(string req, bit rv, logic [31:0] ra);
    ras_pop = 1;
    cyc(req, 0, 0, '0, rv, ra);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check(e.req, e.hit, e.tkn, e.tgt, e.rv, e.ra,
              pred_hit, pred_taken, pred_target, ras_valid, ras_addr);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    check("R1 reset", 0, 0, '0, 0, '0, pred_hit, pred_taken, pred_target, ras_valid, ras_addr);
    rst_n = 1;

    look("R1 empty table", PA, 0, 0, '0);
    resolve("R4 alloc A", PA, 1, 32'h100);
    look("R2 hit A", PA, 1, 1, 32'h100);
    look("R3 alias B", PB, 0, 0, '0);
    lk_pc = PA; cyc("R9 no lookup", 0, 0, '0, 0, '0);
    resolve("R6 nt miss B", PB, 0, 32'h200);
    look("R6 A intact", PA, 1, 1, 32'h100);
    look("R6 B absent", PB, 0, 0, '0);
    resolve("R5 nt hit A", PA, 0, 32'h180);
    look("R5 A not taken", PA, 1, 0, 32'h180);
    resolve("R7 taken hit A", PA, 1, 32'h190);
    look("R7 A retaken", PA, 1, 1, 32'h190);
    lk_en = 1; lk_pc = PA; rs_en = 1; rs_pc = PB; rs_taken = 1; rs_target = 32'h300;
    cyc("R8 old contents", 1, 1, 32'h190, 0, '0);
    look("R4 A evicted", PA, 0, 0, '0);
    look("R4 B resident", PB, 1, 1, 32'h300);
    lk_en = 1; lk_pc = PC; rs_en = 1; rs_pc = PC; rs_taken = 1; rs_target = 32'h400;
    cyc("R8 alloc not seen", 0, 0, '0, 0, '0);
    look("R4 C resident", PC, 1, 1, 32'h400);

    pop("R12 empty pop", 0, '0);
    push("R10 push", 32'hA0);
    push("R10 push", 32'hA4);
    pop("R10 lifo top", 1, 32'hA4);
    pop("R10 lifo next", 1, 32'hA0);
    pop("R12 drained", 0, '0);
    push("R13 push", 32'hB0);
    ras_push = 1; ras_push_addr = 32'hC0; ras_pop = 1;
    cyc("R13 swap returns top", 0, 0, '0, 1, 32'hB0);
    pop("R13 replaced top", 1, 32'hC0);
    pop("R12 empty again", 0, '0);
    ras_push = 1; ras_push_addr = 32'hE0; ras_pop = 1;
    cyc("R13 swap on empty", 0, 0, '0, 0, '0);
    pop("R13 one left", 1, 32'hE0);
    for (int k = 0; k < 9; k++) push("R11 fill", 32'hD00 + 32'(4 * k));
    for (int k = 8; k >= 1; k--) pop("R11 wrap order", 1, 32'hD00 + 32'(4 * k));
    pop("R11 oldest lost", 0, '0);
    lk_en = 1; lk_pc = PB; ras_pop = 1;
    cyc("R2 with empty pop", 1, 1, 32'h300, 0, '0);

    repeat (3) @(negedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule